// File: doc/BRIEF.md
# Pipelined ADC digital error correction

This block sits behind the analog core of a nine-stage pipelined converter. Stages one to eight each resolve a redundant 1.5-bit decision: a signed digit of -1, 0 or +1 from two comparators. The ninth stage is a 2-bit flash. A sample moves one stage forward every half clock. The two decisions that fall inside one clock therefore reach the block together, one clock after the previous pair.

The block holds each stage's decision in its own short delay line. All nine decisions of one sample then meet in the same cycle. The redundant digits are weighted by powers of two and added to the flash code around a mid-scale offset. Because neighbouring digits overlap, a comparator that trips early or late in one stage is corrected by the following stages, and the output has no missing codes. The sum is clamped to the 10-bit range and registered. Every clock a new sample enters, and every clock one corrected word leaves, five clocks after its sample was taken.

Top module: `pipe_adc_corrector`

## Requirements
- R1: A synchronous active-high reset clears all delay lines, the output word (0) and the valid flag (0). The output still reads 0 in the first cycle after reset is released.
- R2: A stage code is decoded as 00 = -1, 01 = 0 and 10 = +1. Lane i (bits 2i+1:2i of `stg_code`, where lane 0 is the first stage) carries weight 2^(8-i).
- R3: The illegal stage code 11 contributes exactly as 10 (+1).
- R4: The 2-bit flash code contributes its unsigned value minus one.
- R5: The word is 512 plus the weighted digits plus the flash contribution. All lanes at 01 with flash 01 give 512.
- R6: A sum above 1023 is output as 1023. The lowest reachable word is 1 (all lanes 00, flash 00).
- R7: Take a sample at rising edge n. Its lane i code is captured at edge n + floor(i/2) + 1, and its flash code at edge n + 5. Its word is on `dout` after edge n + 5. A new sample enters every clock, and neighbouring samples do not disturb each other.
- R8: `dout_vld` stays low through the first five rising edges with reset low. It goes high at the sixth and stays high until the next reset.
- R9: A reset applied in the middle of a stream drops `dout_vld` and clears `dout`. The following stream refills with the same five-cycle delay and the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stg_code | input | 16 | Lane i = bits 2i+1:2i: decision of stage i+1, presented with its stage skew |
| fl_code | input | 2 | Final flash code, presented in the capture cycle of the output |
| dout | output | 10 | Corrected, clamped and registered sample word |
| dout_vld | output | 1 | High once the pipeline has filled after reset |

## Verification
The hardest situation to reach is a misaligned lane. If one delay line is a cycle short or long, a steady input still gives the right word, because every sample looks the same. The stimulus therefore streams a different code pattern every clock, from per-lane sweeps and a pseudo-random generator. Each lane's code is driven at its own skewed cycle, so a wrong delay on any lane mixes in a neighbouring sample's digit and changes the word. Clamping at the top is reached with all lanes at +1 (both codes 10 and 11) and a high flash code. The floor is reached with all lanes at -1.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    localparam int unsigned DEF_STAGES  = 8;
    localparam int unsigned DEF_FLASH_W = 2;

    // Redundant stage decision as it arrives from the comparators.
    typedef enum logic [1:0] {
        RSD_MINUS   = 2'b00,
        RSD_ZERO    = 2'b01,
        RSD_PLUS    = 2'b10,
        RSD_ILLEGAL = 2'b11
    } rsd_code_e;

    // What the adder does with one weighted lane.
    typedef enum logic [1:0] {
        ACT_SUB,
        ACT_HOLD,
        ACT_ADD
    } rsd_act_e;

    // Code 11 cannot come from two thermometer comparators; treat it as +1.
    function automatic rsd_act_e rsd_action(rsd_code_e c);
        case (c)
            RSD_MINUS: return ACT_SUB;
            RSD_ZERO:  return ACT_HOLD;
            default:   return ACT_ADD;
        endcase
    endfunction

    // Two stages resolve per clock, so lane pairs share an arrival cycle.
    function automatic int unsigned lane_depth(int unsigned nstg, int unsigned lane);
        return nstg / 2 - lane / 2;
    endfunction

    // Clocks from sample edge to registered word, output latch included.
    function automatic int unsigned fill_latency(int unsigned nstg);
        return nstg / 2 + 1;
    endfunction

endpackage

// File: rtl/rsd_skew_line.sv
module rsd_skew_line #(
    parameter int unsigned W     = 2,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] tap [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < DEPTH; t++) tap[t] <= '0;
        end else begin
            tap[0] <= din;
            for (int t = 1; t < DEPTH; t++) tap[t] <= tap[t-1];
        end
    end

    assign dout = tap[DEPTH-1];

endmodule

// File: rtl/rsd_sum.sv
module rsd_sum
    import adc_corr_pkg::*;
#(
    parameter int unsigned NSTG = DEF_STAGES,
    parameter int unsigned FLW  = DEF_FLASH_W
) (
    input  logic [2*NSTG-1:0]      codes,
    input  logic [FLW-1:0]         fl,
    output logic [NSTG+FLW-1:0]    word
);

    localparam int unsigned OUT_W  = NSTG + FLW;
    localparam int unsigned SUM_W  = OUT_W + 2;
    localparam int unsigned FL_OFS = (1 << (FLW - 1)) - 1;
    localparam logic signed [SUM_W-1:0] MID_S = SUM_W'(1 << (OUT_W - 1));
    localparam logic signed [SUM_W-1:0] TOP_S = SUM_W'((1 << OUT_W) - 1);
    localparam logic signed [SUM_W-1:0] FLO_S = SUM_W'(FL_OFS);

    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] wt;
    logic signed [SUM_W-1:0] fl_s;

    always_comb begin
        acc  = MID_S;
        wt   = '0;
        for (int i = 0; i < NSTG; i++) begin
            wt = SUM_W'(1) << (OUT_W - 2 - i);
            case (rsd_action(rsd_code_e'(codes[2*i +: 2])))
                ACT_SUB: acc = acc - wt;
                ACT_ADD: acc = acc + wt;
                default: acc = acc;
            endcase
        end
        fl_s = SUM_W'(fl);
        acc  = acc + fl_s - FLO_S;
        if (acc > TOP_S)
            word = '1;
        else if (acc < 0)
            word = '0;
        else
            word = acc[OUT_W-1:0];
    end

    // Pattern detectors for the guard assertions below.
    logic all_mid, all_pos, all_neg;
    always_comb begin
        all_mid = 1'b1;
        all_pos = 1'b1;
        all_neg = 1'b1;
        for (int i = 0; i < NSTG; i++) begin
            all_mid = all_mid & (codes[2*i +: 2] == 2'b01);
            all_pos = all_pos & codes[2*i+1];
            all_neg = all_neg & (codes[2*i +: 2] == 2'b00);
        end
    end

    // R5: zero digits with a centred flash code land on mid-scale.
    always_comb begin
        if (all_mid && fl == FLW'(FL_OFS))
            p_mid_r5: assert (word == OUT_W'(1 << (OUT_W - 1)))
                else $error("mid-scale word wrong");
    end

    // R6: full positive drive saturates at the top code.
    always_comb begin
        if (all_pos && fl == '1)
            p_sat_hi_r6: assert (word == '1)
                else $error("top clamp missing");
    end

    // R6: full negative drive reaches the floor of the range.
    always_comb begin
        if (all_neg && fl == '0)
            p_floor_r6: assert (word == OUT_W'(1))
                else $error("floor word wrong");
    end

endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
    parameter int unsigned LAT = 5
) (
    input  logic clk,
    input  logic rst,
    output logic vld
);

    localparam int unsigned CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            vld <= 1'b0;
        end else begin
            if (cnt != CNT_W'(LAT)) cnt <= cnt + 1'b1;
            vld <= (cnt == CNT_W'(LAT));
        end
    end

    // R8: once valid, valid holds until reset.
    p_vld_hold_r8: assert property (@(posedge clk) disable iff (rst) vld |=> vld)
        else $error("valid dropped without reset");

    // R8: the edge right after reset never shows valid data.
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !vld)
        else $error("valid high straight after reset");

endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
    import adc_corr_pkg::*;
#(
    parameter int unsigned NSTG = DEF_STAGES,
    parameter int unsigned FLW  = DEF_FLASH_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [2*NSTG-1:0]      stg_code,
    input  logic [FLW-1:0]         fl_code,
    output logic [NSTG+FLW-1:0]    dout,
    output logic                   dout_vld
);

    localparam int unsigned OUT_W = NSTG + FLW;
    localparam int unsigned LAT   = fill_latency(NSTG);

    logic [2*NSTG-1:0] aligned;
    logic [OUT_W-1:0]  word_c;

    // One delay line per stage; earlier stages wait longer.
    for (genvar i = 0; i < NSTG; i++) begin : g_lane
        rsd_skew_line #(
            .W     (2),
            .DEPTH (lane_depth(NSTG, i))
        ) u_line (
            .clk  (clk),
            .rst  (rst),
            .din  (stg_code[2*i +: 2]),
            .dout (aligned[2*i +: 2])
        );
    end

    rsd_sum #(
        .NSTG (NSTG),
        .FLW  (FLW)
    ) u_sum (
        .codes (aligned),
        .fl    (fl_code),
        .word  (word_c)
    );

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= word_c;
    end

    fill_tracker #(
        .LAT (LAT)
    ) u_fill (
        .clk (clk),
        .rst (rst),
        .vld (dout_vld)
    );

    // R1: the output register shows its cleared value after reset.
    p_out_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dout == '0 && !dout_vld))
        else $error("output not cleared by reset");

endmodule

// File: tb/tb_pipe_adc_corrector.sv
`timescale 1ns/1ps
module tb_pipe_adc_corrector;

    localparam int NSTG = 8;
    localparam int LAT  = 5;
    localparam int MAXS = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] stg_code = '0;
    logic [1:0]  fl_code  = '0;
    logic [9:0]  dout;
    logic        dout_vld;

    int errs = 0;
    int chks = 0;
    bit done = 1'b0;

    logic [15:0] s_st  [MAXS];
    logic [1:0]  s_fl  [MAXS];
    string       s_req [MAXS];
    int          ns = 0;

    always #2 clk = ~clk;

    pipe_adc_corrector dut (
        .clk      (clk),
        .rst      (rst),
        .stg_code (stg_code),
        .fl_code  (fl_code),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    function automatic int model(logic [15:0] st, logic [1:0] fl);
        int acc = 512;
        for (int i = 0; i < NSTG; i++) begin
            case (st[2*i +: 2])
                2'b00:   acc -= (1 << (8 - i));
                2'b01:   acc += 0;
                default: acc += (1 << (8 - i));
            endcase
        end
        acc += int'(fl) - 1;
        if (acc > 1023) acc = 1023;
        if (acc < 0) acc = 0;
        return acc;
    endfunction

    task automatic check(string req, int act, int exp);
        chks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add(logic [15:0] st, logic [1:0] fl, string req);
        s_st[ns]  = st;
        s_fl[ns]  = fl;
        s_req[ns] = req;
        ns++;
    endtask

    // Streams samples 0..cnt-1 with per-lane skew (R7); first negedge releases reset.
    task automatic run_stream(int cnt, string fill_req);
        for (int c = 0; c < cnt + LAT; c++) begin
            int sf;
            @(negedge clk);
            if (c == 0) rst = 1'b0;
            for (int i = 0; i < NSTG; i++) begin
                int sl;
                sl = c - i / 2 - 1;
                stg_code[2*i +: 2] = (sl >= 0 && sl < cnt) ? s_st[sl][2*i +: 2] : 2'b01;
            end
            sf = c - LAT;
            fl_code = (sf >= 0 && sf < cnt) ? s_fl[sf] : 2'b01;
            @(posedge clk);
            #1;
            if (c < LAT) begin
                check(fill_req, int'(dout_vld), 0);
            end else begin
                check((c == LAT) ? "R7" : "R8", int'(dout_vld), 1);
                check(s_req[c-LAT], int'(dout), model(s_st[c-LAT], s_fl[c-LAT]));
            end
        end
    endtask

    initial begin
        logic [31:0] lf;
        logic [15:0] base;
        // R5: mid-scale sample.
        add(16'h5555, 2'b01, "R5");
        // R2 and R3: each lane swept through all codes, others at zero digit.
        for (int i = 0; i < NSTG; i++) begin
            for (int k = 0; k < 4; k++) begin
                base = 16'h5555;
                base[2*i +: 2] = 2'(k);
                add(base, 2'(i + k), (k == 3) ? "R3" : "R2");
            end
        end
        // R4: flash code alone.
        for (int k = 0; k < 4; k++) add(16'h5555, 2'(k), "R4");
        // R6: clamp and floor.
        add(16'hAAAA, 2'b11, "R6");
        add(16'hFFFF, 2'b10, "R6");
        add(16'hAAAA, 2'b01, "R6");
        add(16'h0000, 2'b00, "R6");
        add(16'hFFFF, 2'b11, "R6");
        // R7: pseudo-random stream, a new pattern every clock.
        lf = 32'hACE1_2345;
        for (int n = 0; n < 150; n++) begin
            for (int b = 0; b < 18; b++) lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            add(lf[15:0], lf[17:16], "R7");
        end

        // R1: state during reset.
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(dout), 0);
        check("R1", int'(dout_vld), 0);

        run_stream(ns, "R8");

        // R9: reset in mid-stream.
        @(negedge clk);
        rst = 1'b1;
        stg_code = 16'hAAAA;
        fl_code  = 2'b11;
        repeat (2) @(posedge clk);
        #1;
        check("R9", int'(dout), 0);
        check("R9", int'(dout_vld), 0);
        run_stream(24, "R9");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            errs++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end

endmodule